// File: doc/BRIEF.md
# Cluster Debug Halt Coordinator

This block ties the debug halts of a small cluster of cores together. Each core raises a halt line and reports, alongside it, a four-bit vector of reasons for the halt. Software first chooses which cores take part and which reasons count. From then on, a qualifying halt on any one participating core sends a halt request to every participating core on the next clock.

A second, independent core mask decides which halted cores stop a shared 64-bit free-running counter. The counter advances by one on every clock in which no core in that mask is halted. This keeps a cluster-wide timebase from drifting while a core sits in the debugger.

Software reaches both masks through a single command strobe. The strobe carries a 4-bit code, an 8-bit parameter and a 32-bit data word. Read commands load a registered readback word one clock later.

Top module: `dhc_top`

## Requirements
- R1: While reset is asserted and right after it, the select mask, cause mask and counter mask are zero, halt_req is zero, readback is zero and the counter holds zero.
- R2: Code 4'h1 (set select) loads the cause mask from cmd_param[3:0] and the participating-core mask from cmd_data[NCORE-1:0]. The new masks act from the clock after the strobe.
- R3: Codes 4'h2 (read select) and 4'h3 (read cause) both load readback with the participating-core mask, zero-extended, one clock after the strobe.
- R4: A core qualifies when its halt line is high, its select bit is set, and its cause vector shares a set bit with the cause mask. Cause bit 0 is the halt flag, bit 1 an actionpoint, bit 2 a breakpoint and bit 3 a self-halt, with core i using halt_cause[4i+3:4i]. One clock after any core qualifies, halt_req equals the select mask.
- R5: halt_req stays asserted for as long as a qualifying event is present. It returns to zero one clock after the last qualifying event clears.
- R6: A halt on an unselected core, or one whose causes are all disabled, leaves halt_req at zero.
- R7: Code 4'h4 loads the counter mask from cmd_data[NCORE-1:0]. Code 4'h5 loads readback with the counter mask, zero-extended, one clock later.
- R8: The counter adds one on each clock edge at which no core in the counter mask has its halt line high. While such a core is halted, cnt_frozen is high in that same cycle and the counter keeps its value.
- R9: A strobe carrying any other code changes neither readback nor any mask.
- R10: When a mask write and a halt event share a cycle, the halt is judged against the masks in force before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_evt | input | NCORE | Per-core halt indication |
| halt_cause | input | 4*NCORE | Per-core cause vector, four bits per core |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code |
| cmd_param | input | 8 | Command parameter |
| cmd_data | input | 32 | Command data word |
| readback | output | 32 | Registered read result |
| halt_req | output | NCORE | Halt request to each core |
| cnt_frozen | output | 1 | Counter held this cycle |
| gcnt | output | 64 | Shared free-running counter |

## Verification
The mask-write path and the halt-qualification path can act in the same cycle. This happens when software reprograms the select and cause masks while a core is already reporting a halt. The bench provokes it with a set-select strobe that widens the select mask to every core and enables every cause. In that same cycle, a core outside the old mask self-halts. The expected halt_req is zero on the next clock, because the old mask still rules, and all ones on the clock after, while the halt is still held.

// File: rtl/dhc_pkg.sv
package dhc_pkg;
  localparam int CAUSE_W = 4;
  localparam int CODE_W  = 4;

  typedef enum logic [CODE_W-1:0] {
    CMD_DBG_SET      = 4'h1,
    CMD_DBG_RD_SEL   = 4'h2,
    CMD_DBG_RD_CAUSE = 4'h3,
    CMD_CNT_SET      = 4'h4,
    CMD_CNT_RD       = 4'h5
  } dhc_cmd_e;

  function automatic logic cmd_known(input logic [CODE_W-1:0] code);
    return (code >= 4'h1) && (code <= 4'h5);
  endfunction
endpackage

// File: rtl/dhc_cmd_regs.sv
module dhc_cmd_regs
  import dhc_pkg::*;
#(
  parameter int NCORE   = 4,
  parameter int PARAM_W = 8,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [CODE_W-1:0]   cmd_code,
  input  logic [PARAM_W-1:0]  cmd_param,
  input  logic [DATA_W-1:0]   cmd_data,
  output logic [NCORE-1:0]    sel_mask,
  output logic [CAUSE_W-1:0]  cause_mask,
  output logic [NCORE-1:0]    cnt_mask,
  output logic [DATA_W-1:0]   readback,
  output logic                cmd_unknown
);
  localparam int PAD_W = DATA_W - NCORE;

  function automatic logic [DATA_W-1:0] widen(input logic [NCORE-1:0] m);
    return {{PAD_W{1'b0}}, m};
  endfunction

  assign cmd_unknown = cmd_valid && !cmd_known(cmd_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_mask   <= '0;
      cause_mask <= '0;
      cnt_mask   <= '0;
      readback   <= '0;
    end else if (cmd_valid) begin
      case (cmd_code)
        CMD_DBG_SET: begin
          sel_mask   <= cmd_data[NCORE-1:0];
          cause_mask <= cmd_param[CAUSE_W-1:0];
        end
        CMD_DBG_RD_SEL,
        CMD_DBG_RD_CAUSE: readback <= widen(sel_mask);
        CMD_CNT_SET:      cnt_mask <= cmd_data[NCORE-1:0];
        CMD_CNT_RD:       readback <= widen(cnt_mask);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dhc_halt_fanout.sv
module dhc_halt_fanout
  import dhc_pkg::*;
#(
  parameter int NCORE = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCORE-1:0]           halt_evt,
  input  logic [NCORE*CAUSE_W-1:0]   halt_cause,
  input  logic [NCORE-1:0]           sel_mask,
  input  logic [CAUSE_W-1:0]         cause_mask,
  output logic [NCORE-1:0]           qual_vec,
  output logic                       qual_any,
  output logic [NCORE-1:0]           halt_req
);
  function automatic logic core_qualifies(input logic evt, input logic sel,
                                          input logic [CAUSE_W-1:0] cause,
                                          input logic [CAUSE_W-1:0] enab);
    return evt && sel && ((cause & enab) != '0);
  endfunction

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    assign qual_vec[i] = core_qualifies(halt_evt[i], sel_mask[i],
                                        halt_cause[i*CAUSE_W +: CAUSE_W],
                                        cause_mask);
  end

  assign qual_any = |qual_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_req <= '0;
    else        halt_req <= qual_any ? sel_mask : '0;
  end
endmodule

// File: rtl/dhc_gcounter.sv
module dhc_gcounter #(
  parameter int NCORE = 4,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] halt_evt,
  input  logic [NCORE-1:0] cnt_mask,
  output logic             frozen,
  output logic [CNT_W-1:0] count
);
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic hold);
    return hold ? c : c + CNT_W'(1);
  endfunction

  assign frozen = |(halt_evt & cnt_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= next_count(count, frozen);
  end
endmodule

// File: rtl/dhc_top.sv
module dhc_top
  import dhc_pkg::*;
#(
  parameter int NCORE   = 4,
  parameter int PARAM_W = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCORE-1:0]         halt_evt,
  input  logic [NCORE*4-1:0]       halt_cause,
  input  logic                     cmd_valid,
  input  logic [3:0]               cmd_code,
  input  logic [PARAM_W-1:0]       cmd_param,
  input  logic [DATA_W-1:0]        cmd_data,
  output logic [DATA_W-1:0]        readback,
  output logic [NCORE-1:0]         halt_req,
  output logic                     cnt_frozen,
  output logic [CNT_W-1:0]         gcnt
);
  logic [NCORE-1:0]   sel_mask;
  logic [CAUSE_W-1:0] cause_mask;
  logic [NCORE-1:0]   cnt_mask;
  logic               cmd_unknown;
  logic [NCORE-1:0]   qual_vec;
  logic               qual_any;

  dhc_cmd_regs #(.NCORE(NCORE), .PARAM_W(PARAM_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_param(cmd_param), .cmd_data(cmd_data), .sel_mask(sel_mask),
    .cause_mask(cause_mask), .cnt_mask(cnt_mask), .readback(readback),
    .cmd_unknown(cmd_unknown)
  );

  dhc_halt_fanout #(.NCORE(NCORE)) u_fan (
    .clk(clk), .rst_n(rst_n), .halt_evt(halt_evt), .halt_cause(halt_cause),
    .sel_mask(sel_mask), .cause_mask(cause_mask), .qual_vec(qual_vec),
    .qual_any(qual_any), .halt_req(halt_req)
  );

  dhc_gcounter #(.NCORE(NCORE), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .halt_evt(halt_evt), .cnt_mask(cnt_mask),
    .frozen(cnt_frozen), .count(gcnt)
  );
endmodule

// File: rtl/dhc_checker.sv
module dhc_checker #(
  parameter int NCORE  = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCORE-1:0]  halt_evt,
  input logic [NCORE-1:0]  sel_mask,
  input logic [NCORE-1:0]  cnt_mask,
  input logic              qual_any,
  input logic              cmd_unknown,
  input logic [DATA_W-1:0] readback,
  input logic [NCORE-1:0]  halt_req,
  input logic              cnt_frozen,
  input logic [CNT_W-1:0]  gcnt
);
  assert_fanout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    qual_any |=> (halt_req == $past(sel_mask)));

  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_any |=> (halt_req == '0));

  assert_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_frozen |=> (gcnt == $past(gcnt) + CNT_W'(1)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_frozen |=> $stable(gcnt));

  assert_freeze_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_frozen |-> ((halt_evt & cnt_mask) != '0));

  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_unknown |=> ($stable(readback) && $stable(sel_mask) && $stable(cnt_mask)));
endmodule

bind dhc_top dhc_checker #(.NCORE(NCORE), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt_evt(halt_evt), .sel_mask(sel_mask),
  .cnt_mask(cnt_mask), .qual_any(qual_any), .cmd_unknown(cmd_unknown),
  .readback(readback), .halt_req(halt_req), .cnt_frozen(cnt_frozen), .gcnt(gcnt)
);

// File: tb/tb_dhc_top.sv
module tb_dhc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;
  localparam int WATCHDOG = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  halt_evt = '0;
  logic [15:0] halt_cause = '0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_code = '0;
  logic [7:0]  cmd_param = '0;
  logic [31:0] cmd_data = '0;
  logic [31:0] readback;
  logic [3:0]  halt_req;
  logic        cnt_frozen;
  logic [63:0] gcnt;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dhc_top dut (
    .clk(clk), .rst_n(rst_n), .halt_evt(halt_evt), .halt_cause(halt_cause),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_param(cmd_param),
    .cmd_data(cmd_data), .readback(readback), .halt_req(halt_req),
    .cnt_frozen(cnt_frozen), .gcnt(gcnt)
  );

  // fields: valid, code, param, data[7:0], evt, cause, expected readback[7:0], expected halt_req
  localparam logic [52:0] VEC [0:NV-1] = '{
    {1'b1, 4'h2, 8'h00, 8'h00, 4'b0000, 16'h0000, 8'h00, 4'h0}, // R3 read after reset
    {1'b1, 4'h1, 8'h04, 8'h05, 4'b0000, 16'h0000, 8'h00, 4'h0}, // R2 set: breakpoint, cores 0,2
    {1'b1, 4'h2, 8'h00, 8'h00, 4'b0000, 16'h0000, 8'h05, 4'h0}, // R3 read select
    {1'b1, 4'h3, 8'h00, 8'h00, 4'b0000, 16'h0000, 8'h05, 4'h0}, // R3 read cause code
    {1'b0, 4'h0, 8'h00, 8'h00, 4'b0001, 16'h0004, 8'h05, 4'h5}, // R4 core0 breakpoint
    {1'b0, 4'h0, 8'h00, 8'h00, 4'b0001, 16'h0004, 8'h05, 4'h5}, // R5 held
    {1'b0, 4'h0, 8'h00, 8'h00, 4'b0000, 16'h0000, 8'h05, 4'h0}, // R5 released
    {1'b0, 4'h0, 8'h00, 8'h00, 4'b0001, 16'h0002, 8'h05, 4'h0}, // R6 disabled cause
    {1'b0, 4'h0, 8'h00, 8'h00, 4'b0010, 16'h0040, 8'h05, 4'h0}, // R6 unselected core
    {1'b1, 4'hE, 8'hFF, 8'hFF, 4'b0000, 16'h0000, 8'h05, 4'h0}, // R9 unknown code
    {1'b1, 4'h4, 8'h00, 8'h02, 4'b0000, 16'h0000, 8'h05, 4'h0}, // R7 counter mask core1
    {1'b1, 4'h5, 8'h00, 8'h00, 4'b0000, 16'h0000, 8'h02, 4'h0}, // R7 read counter mask
    {1'b1, 4'h2, 8'h00, 8'h00, 4'b0000, 16'h0000, 8'h05, 4'h0}, // R9 select mask intact
    {1'b1, 4'h1, 8'h0F, 8'h0F, 4'b1000, 16'h8000, 8'h05, 4'h0}, // R10 write + halt same cycle
    {1'b0, 4'h0, 8'h00, 8'h00, 4'b1000, 16'h8000, 8'h05, 4'hF}, // R10 new mask now rules
    {1'b0, 4'h0, 8'h00, 8'h00, 4'b0000, 16'h0000, 8'h05, 4'h0}, // R5 released
    {1'b0, 4'h0, 8'h00, 8'h00, 4'b0100, 16'h0100, 8'h05, 4'hF}  // R4 core2 halt flag
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [63:0] c0;
    repeat (3) @(negedge clk);
    check("R1 readback", {32'h0, readback}, 64'h0);
    check("R1 halt_req", {60'h0, halt_req}, 64'h0);
    check("R1 gcnt", gcnt, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first count", gcnt, 64'h1);
    check("R1 not frozen", {63'h0, cnt_frozen}, 64'h0);

    for (int k = 0; k < NV; k++) begin
      cmd_valid  = VEC[k][52];
      cmd_code   = VEC[k][51:48];
      cmd_param  = VEC[k][47:40];
      cmd_data   = {24'h0, VEC[k][39:32]};
      halt_evt   = VEC[k][31:28];
      halt_cause = VEC[k][27:12];
      @(negedge clk);
      check($sformatf("R2-R10 vec%0d readback", k), {32'h0, readback}, {56'h0, VEC[k][11:4]});
      check($sformatf("R4-R6 vec%0d halt_req", k), {60'h0, halt_req}, {60'h0, VEC[k][3:0]});
    end
    cmd_valid = 1'b0; halt_evt = '0; halt_cause = '0;

    // R8 free run
    @(negedge clk);
    c0 = gcnt;
    @(negedge clk);
    check("R8 increment", gcnt, c0 + 64'h1);

    // R8 core0 not in counter mask: no freeze
    halt_evt = 4'b0001;
    #1;
    check("R8 unmasked no freeze", {63'h0, cnt_frozen}, 64'h0);
    c0 = gcnt;
    @(negedge clk);
    check("R8 unmasked counts", gcnt, c0 + 64'h1);

    // R8 core1 in counter mask: freeze
    halt_evt = 4'b0010;
    #1;
    check("R8 frozen flag", {63'h0, cnt_frozen}, 64'h1);
    c0 = gcnt;
    repeat (3) @(negedge clk);
    check("R8 frozen hold", gcnt, c0);
    halt_evt = 4'b0000;
    @(negedge clk);
    check("R8 resume", gcnt, c0 + 64'h1);
    check("R8 released flag", {63'h0, cnt_frozen}, 64'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule